// File: doc/BRIEF.md
# Serial EEPROM Slave on a Two-Wire Bus

The block is a synthesizable model of a 256-byte serial EEPROM that answers as a slave on a two-wire (I2C) bus. It runs on a fast system clock and oversamples the clock and data lines through synchronizers. It never drives a line high. When it must pull the data line low, it raises an open-drain enable output, and it changes that enable only while the bus clock is low.

A master first sends a control byte, seven fixed address bits followed by a read/write flag. The master can then do one of three things:
- set the internal word pointer, then write one byte, which is stored when the STOP condition arrives;
- set the pointer, issue a repeated START, and read bytes from that address onward;
- read directly from wherever the pointer already is.

After each stored byte the device stays busy for a fixed number of system clocks. While busy it refuses its own control byte, so the master polls until it gets an acknowledge.

Top module: `eep_i2c_slave`

## Requirements
- R1: After reset, `sda_oe_o` is 0, so the bus is released, and every array byte reads back as 0x00.
- R2: When the device is not busy, a control byte whose upper seven bits are 1010000 is acknowledged. Bit 0 of that byte selects the direction: 0 is write and 1 is read. An acknowledge means the device holds SDA low throughout the ninth SCL clock of the transfer.
- R3: A control byte with any other upper seven bits is not acknowledged. After such a byte the device drives nothing, even for bytes that would match, until the next START (SDA falling while SCL is high).
- R4: In the sequence START, 0xA0, address, data, STOP, the device acknowledges all three bytes, and the data byte can later be read back from that address.
- R5: In the sequence START, 0xA0, address, repeated START, 0xA1, the device returns the byte stored at that address, MSB first, over eight SCL clocks.
- R6: In a multi-byte read, each byte the master acknowledges is followed by the byte at the next address, and address 0xFF is followed by 0x00.
- R7: Once the master does not acknowledge a read byte (SDA high in the ninth clock), the device drives nothing until the next START.
- R8: For BUSY_CYCLES system clocks after the STOP that stores a byte, the control byte 0xA0 is not acknowledged. Once that period has passed, it is acknowledged again.
- R9: A byte is stored only at a STOP (SDA rising while SCL is high). A data byte followed by a repeated START instead leaves the array unchanged and does not start a busy period.
- R10: `sda_oe_o` never changes while SCL is high on a well-formed bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
The embedded properties check the following on every cycle:
- the data-line enable changes only after a low SCL sample, or as a START or STOP clears it;
- the enable is released whenever the controller is idle;
- no acknowledge of the control byte is driven while busy;
- the bit counter never passes the frame length;
- the word pointer advances by exactly one at the end of each read byte.

Only the bench's bus scenarios show the values on the wire. These include the byte read back after a write, the wrap from 0xFF to 0x00, and the refusal and later acceptance of the control byte around the busy window. They also include a byte being discarded by a repeated START, and silence after a foreign control byte or a master NACK.

// File: rtl/eep_pkg.sv
package eep_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_CTRL,
        S_CACK,
        S_ADDR,
        S_AACK,
        S_WDAT,
        S_WACK,
        S_RDAT,
        S_RACK
    } eep_state_e;
endpackage

// File: rtl/eep_bus_sampler.sv
module eep_bus_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe_q, scl_pipe_d;
    logic [STAGES-1:0] sda_pipe_q, sda_pipe_d;
    logic              scl_prev_q, scl_prev_d;
    logic              sda_prev_q, sda_prev_d;

    always_comb begin
        scl_pipe_d = {scl_pipe_q[STAGES-2:0], scl_i};
        sda_pipe_d = {sda_pipe_q[STAGES-2:0], sda_i};
        scl_prev_d = scl_pipe_q[STAGES-1];
        sda_prev_d = sda_pipe_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe_q <= '1;
            sda_pipe_q <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_pipe_q <= scl_pipe_d;
            sda_pipe_q <= sda_pipe_d;
            scl_prev_q <= scl_prev_d;
            sda_prev_q <= sda_prev_d;
        end
    end

    assign scl_s     = scl_pipe_q[STAGES-1];
    assign sda_s     = sda_pipe_q[STAGES-1];
    assign scl_rise  = scl_s & ~scl_prev_q;
    assign scl_fall  = ~scl_s & scl_prev_q;
    assign start_det = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
    assign stop_det  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '{default: '0};
        else        mem_q <= mem_d;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/eep_busy_timer.sv
module eep_busy_timer #(
    parameter int BUSY_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic busy_o
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)              cnt_d = CW'(BUSY_CYCLES);
        else if (cnt_q != '0)    cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/eep_i2c_slave.sv
module eep_i2c_slave
    import eep_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter int          DATA_W      = 8,
    parameter logic [6:0]  DEV_ID      = 7'b1010000,
    parameter int          BUSY_CYCLES = 2000,
    parameter int          SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe_o
);
    localparam int BCW = $clog2(DATA_W + 1);
    localparam logic [BCW-1:0] FRAME_BITS = BCW'(DATA_W);

    typedef struct packed {
        eep_state_e        state;
        logic [BCW-1:0]    bitcnt;
        logic [DATA_W-1:0] shreg;
        logic [ADDR_W-1:0] ptr;
        logic [DATA_W-1:0] wdata;
        logic              pending;
        logic              rd;
        logic              mack;
        logic              oe;
    } slv_t;

    slv_t st_q, st_d;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic busy, mem_we, busy_load;
    logic [DATA_W-1:0] rd_data;

    eep_bus_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    eep_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (st_q.ptr),
        .wdata (st_q.wdata),
        .raddr (st_q.ptr),
        .rdata (rd_data)
    );

    eep_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (busy_load),
        .busy_o (busy)
    );

    always_comb begin
        st_d      = st_q;
        mem_we    = 1'b0;
        busy_load = 1'b0;
        if (start_det) begin
            st_d.state   = S_CTRL;
            st_d.bitcnt  = '0;
            st_d.oe      = 1'b0;
            st_d.pending = 1'b0;
        end else if (stop_det) begin
            if (st_q.pending) begin
                mem_we    = 1'b1;
                busy_load = 1'b1;
                st_d.ptr  = st_q.ptr + ADDR_W'(1);
            end
            st_d.pending = 1'b0;
            st_d.state   = S_IDLE;
            st_d.oe      = 1'b0;
        end else begin
            case (st_q.state)
                S_CTRL, S_ADDR, S_WDAT: begin
                    if (scl_rise) begin
                        st_d.shreg  = {st_q.shreg[DATA_W-2:0], sda_s};
                        st_d.bitcnt = st_q.bitcnt + BCW'(1);
                    end else if (scl_fall && st_q.bitcnt == FRAME_BITS) begin
                        st_d.bitcnt = '0;
                        case (st_q.state)
                            S_CTRL: begin
                                if (st_q.shreg[DATA_W-1 -: 7] == DEV_ID && !busy) begin
                                    st_d.oe    = 1'b1;
                                    st_d.rd    = st_q.shreg[0];
                                    st_d.state = S_CACK;
                                end else begin
                                    st_d.state = S_IDLE;
                                end
                            end
                            S_ADDR: begin
                                st_d.ptr   = st_q.shreg[ADDR_W-1:0];
                                st_d.oe    = 1'b1;
                                st_d.state = S_AACK;
                            end
                            default: begin
                                st_d.wdata   = st_q.shreg;
                                st_d.pending = 1'b1;
                                st_d.oe      = 1'b1;
                                st_d.state   = S_WACK;
                            end
                        endcase
                    end
                end
                S_CACK: begin
                    if (scl_fall) begin
                        if (st_q.rd) begin
                            st_d.shreg = rd_data;
                            st_d.oe    = ~rd_data[DATA_W-1];
                            st_d.state = S_RDAT;
                        end else begin
                            st_d.oe    = 1'b0;
                            st_d.state = S_ADDR;
                        end
                    end
                end
                S_AACK: begin
                    if (scl_fall) begin
                        st_d.oe    = 1'b0;
                        st_d.state = S_WDAT;
                    end
                end
                S_WACK: begin
                    if (scl_fall) begin
                        st_d.oe    = 1'b0;
                        st_d.state = S_IDLE;
                    end
                end
                S_RDAT: begin
                    if (scl_rise) begin
                        st_d.bitcnt = st_q.bitcnt + BCW'(1);
                    end else if (scl_fall) begin
                        if (st_q.bitcnt == FRAME_BITS) begin
                            st_d.oe     = 1'b0;
                            st_d.bitcnt = '0;
                            st_d.ptr    = st_q.ptr + ADDR_W'(1);
                            st_d.state  = S_RACK;
                        end else begin
                            st_d.shreg = {st_q.shreg[DATA_W-2:0], 1'b0};
                            st_d.oe    = ~st_q.shreg[DATA_W-2];
                        end
                    end
                end
                S_RACK: begin
                    if (scl_rise) begin
                        st_d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (st_q.mack) begin
                            st_d.shreg = rd_data;
                            st_d.oe    = ~rd_data[DATA_W-1];
                            st_d.state = S_RDAT;
                        end else begin
                            st_d.oe    = 1'b0;
                            st_d.state = S_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= S_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_oe_o = st_q.oe;

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.oe != $past(st_q.oe)) |-> (!$past(scl_s) || $past(start_det) || $past(stop_det))) // R10
        else $error("data enable changed while SCL high");

    AST_NO_ACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == S_CACK && st_q.oe) |-> !busy) // R8
        else $error("control byte acknowledged while busy");

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == S_IDLE) |-> !st_q.oe) // R7
        else $error("bus driven while idle");

    AST_FRAME_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.bitcnt <= FRAME_BITS) // R5
        else $error("bit counter past frame");

    AST_SEQ_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == S_RDAT && st_d.state == S_RACK) |=> st_q.ptr == $past(st_q.ptr) + ADDR_W'(1)) // R6
        else $error("pointer did not advance by one");
endmodule

// File: tb/tb_eep_i2c_slave.sv
module tb_eep_i2c_slave;
    localparam int Q    = 10;
    localparam int BUSY = 600;
    localparam int NV   = 6;
    localparam logic [15:0] VEC [NV] = '{
        16'h005A, 16'h01C3, 16'h7F81, 16'hFE3C, 16'hFFA5, 16'h1001
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe_o;
    logic sda_line;
    logic oe_prev = 1'b0;
    int   n_chk = 0;
    int   n_bad = 0;
    int   viol  = 0;

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe_o;

    eep_i2c_slave #(.BUSY_CYCLES(BUSY)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe_o)
    );

    always @(posedge clk) begin
        if (rst_n && scl_m && (sda_oe_o != oe_prev)) viol <= viol + 1;
        oe_prev <= sda_oe_o;
    end

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic clk_bit(input logic drv, output logic seen);
        sda_m = drv; wq();
        scl_m = 1'b1; wq();
        seen = sda_line; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            d[i] = s;
        end
        clk_bit(~give_ack, s);
    endtask

    task automatic set_ptr_and_read(input logic [7:0] a, input string req, output logic [7:0] d);
        logic ack;
        send_byte(a, ack);        check(req, ack, 1);
        bus_start();
        send_byte(8'hA1, ack);    check(req, ack, 1);
        recv_byte(1'b0, d);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic       ack;
        logic [7:0] d;
        int         tries;

        repeat (4) @(negedge clk);
        check("R1 reset enable", sda_oe_o, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 released after reset", sda_oe_o, 0);

        // R1 / R5: cleared array seen through random read
        bus_start();
        send_byte(8'hA0, ack);   check("R2 write control ack", ack, 1);
        set_ptr_and_read(8'h10, "R5", d);
        check("R1 cleared byte", d, 8'h00);

        // table walk: write, busy poll, read back
        for (int k = 0; k < NV; k++) begin
            bus_start();
            send_byte(8'hA0, ack);          check("R4 ctrl ack", ack, 1);
            send_byte(VEC[k][15:8], ack);   check("R4 addr ack", ack, 1);
            send_byte(VEC[k][7:0], ack);    check("R4 data ack", ack, 1);
            bus_stop();
            bus_start();
            send_byte(8'hA0, ack);          check("R8 busy nack", ack, 0);
            bus_stop();
            tries = 0;
            ack = 1'b0;
            while (!ack && tries < 20) begin
                bus_start();
                send_byte(8'hA0, ack);
                if (!ack) bus_stop();
                tries++;
            end
            check("R8 ack after busy", ack, 1);
            set_ptr_and_read(VEC[k][15:8], "R5", d);
            check("R4 read back", d, VEC[k][7:0]);
        end

        // R6: sequential read across the wrap, R7 silence after NACK
        bus_start();
        send_byte(8'hA0, ack);   check("R6 ctrl ack", ack, 1);
        send_byte(8'hFE, ack);   check("R6 addr ack", ack, 1);
        bus_start();
        send_byte(8'hA1, ack);   check("R6 read ctrl ack", ack, 1);
        recv_byte(1'b1, d);      check("R6 byte FE", d, 8'h3C);
        recv_byte(1'b1, d);      check("R6 byte FF", d, 8'hA5);
        recv_byte(1'b1, d);      check("R6 wrap byte 00", d, 8'h5A);
        recv_byte(1'b0, d);      check("R6 byte 01", d, 8'hC3);
        send_byte(8'h00, ack);
        check("R7 no ack after master nack", ack, 0);
        recv_byte(1'b0, d);      check("R7 line released", d, 8'hFF);
        bus_stop();

        // R3: foreign control byte, then ignored traffic
        bus_start();
        send_byte(8'hA2, ack);   check("R3 foreign nack", ack, 0);
        send_byte(8'hA0, ack);   check("R3 ignored until start", ack, 0);
        recv_byte(1'b0, d);      check("R3 no drive", d, 8'hFF);
        bus_start();
        send_byte(8'h50, ack);   check("R3 shifted id nack", ack, 0);
        bus_start();
        send_byte(8'hA0, ack);   check("R3 back after start", ack, 1);
        bus_stop();

        // R9: repeated START instead of STOP discards the data byte
        bus_start();
        send_byte(8'hA0, ack);   check("R9 ctrl ack", ack, 1);
        send_byte(8'h01, ack);   check("R9 addr ack", ack, 1);
        send_byte(8'h77, ack);   check("R9 data ack", ack, 1);
        bus_start();
        send_byte(8'hA1, ack);   check("R9 no busy period", ack, 1);
        recv_byte(1'b0, d);      check("R9 old byte kept", d, 8'hC3);
        bus_stop();

        // R2: direct read from the current pointer
        bus_start();
        send_byte(8'hA1, ack);   check("R2 read control ack", ack, 1);
        recv_byte(1'b0, d);      check("R2 current byte", d, 8'h00);
        bus_stop();
        wq();

        check("R10 enable changes with SCL high", viol, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule